// File: doc/BRIEF.md
# Instruction-Driven Nibble Port Controller

This block sits between the decode stage of a small 4-bit controller and its pads. Each cycle it may receive one port command: a port number, an operation and a 4-bit argument. The argument is used as write data, as a bit mask, or as a direction pattern, depending on the operation. The block keeps the output latches and direction state for five 4-bit ports and drives the pad data and enable lines from them. It registers the value of a read and the skip decision of a bit test, and returns both to the core one cycle after the command.

The five ports each behave differently:
- **Port 0** is input-only.
- **Port 1** is a push-pull output.
- **Port 2** is bidirectional. Its whole nibble follows the kind of the last command that touched it.
- **Port 3** is bidirectional with a separate direction bit per pin, loaded by an explicit command.
- **Port 4** is an open-drain output.

A synchronous reset sets each group to its safe pad state. A backup input idles all pads and blanks all pin reads, while the latch contents are kept.

Top module: `io_port_ctrl`

## Requirements
- R1: After reset, port 1 drives all pins low (`out_oe_o`=1111, `out_data_o`=0000), ports 2 and 3 are inputs (enables 0000), the open-drain port is released (`od_pull_o`=0000), and `rd_data_o` and `skip_o` are 0.
- R2: A write, set-bits or clear-bits command to port 2 switches all four of its pins to output (`auto_oe_o`=1111).
- R3: A read, test-true or test-false command to port 2 switches all four of its pins to input. The value it reads or tests is the pin level `auto_pad_i`, captured at the same edge at which the enable drops.
- R4: A direction command (op 7) to port 3 loads the argument as per-pin direction (1 = output) into `dir_oe_o`. A read of port 3 returns the latch bit for output pins and the pin level for input pins.
- R5: A write (op 2) loads the argument into the addressed latch. Set-bits (op 3) ORs the mask into the latch and clear-bits (op 4) clears the masked bits. Unmasked bits keep their value.
- R6: Test-true (op 5) sets `skip_o` when every masked bit of the port value is 1. Test-false (op 6) sets it when every masked bit is 0. A zero mask skips for both. `skip_o` is high only in the cycle after the test.
- R7: One cycle after `backup_i` rises, every output enable and `od_pull_o` are 0, and reads of ports 0, 2 and 3 return 0. Commands still update the latches, and the pads show the latch state again one cycle after `backup_i` falls.
- R8: Each port 4 latch bit at 1 turns on its pull-down (`od_pull_o` bit = 1). A latch bit at 0 leaves the pin released.
- R9: Port numbers 5 to 15 are unimplemented. A read of one returns 0, a write changes no pad, test-false on one skips, and test-true with a nonzero mask does not skip.
- R10: Encoding: op 1 read, 2 write, 3 set-bits, 4 clear-bits, 5 test-true, 6 test-false, 7 direction, 0 none. Ports 0 to 4 are input, push-pull, auto-direction, per-bit, open-drain. A read updates `rd_data_o` one cycle after `cmd_valid_i` and holds it until the next read. Reads of ports 1 and 4 return the latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| backup_i | input | 1 | Backup mode request |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_op_i | input | 3 | Operation code |
| cmd_port_i | input | 4 | Port number |
| cmd_arg_i | input | 4 | Data, mask or direction argument |
| in_pad_i | input | 4 | Port 0 pin levels |
| auto_pad_i | input | 4 | Port 2 pin levels |
| dir_pad_i | input | 4 | Port 3 pin levels |
| out_data_o | output | 4 | Port 1 pin data |
| out_oe_o | output | 4 | Port 1 pin enables |
| auto_data_o | output | 4 | Port 2 pin data |
| auto_oe_o | output | 4 | Port 2 pin enables |
| dir_data_o | output | 4 | Port 3 pin data |
| dir_oe_o | output | 4 | Port 3 pin enables |
| od_pull_o | output | 4 | Port 4 pull-down enables |
| rd_data_o | output | 4 | Registered read result |
| skip_o | output | 1 | Registered test skip decision |

## Verification
On port 2, a read or test that arrives while the port is driving must do two things at one clock edge: drop the enables and capture the external pin level. The bench first puts port 2 in output mode with a latch value that differs from the value on `auto_pad_i`. It then issues the read and requires both the cleared enable and the pin value one cycle later. A second collision arises when a command coincides with backup. A write is issued while backup is active; the bench checks that the enables stay off, and that after release the pads show the written value.

// File: rtl/ioc_pkg.sv
package ioc_pkg;
  typedef enum logic [2:0] {
    OP_NOP = 3'd0, OP_RD = 3'd1, OP_WR = 3'd2, OP_SET = 3'd3,
    OP_CLR = 3'd4, OP_TST1 = 3'd5, OP_TST0 = 3'd6, OP_DIR = 3'd7
  } ioc_op_e;

  typedef enum int { K_OUT, K_AUTO, K_BIT, K_OD } ioc_kind_e;

  localparam int PN_IN   = 0;
  localparam int PN_OUT  = 1;
  localparam int PN_AUTO = 2;
  localparam int PN_BIT  = 3;
  localparam int PN_OD   = 4;
  localparam int N_PORTS = 5;

  function automatic logic is_in_op(ioc_op_e op);
    return (op == OP_RD) || (op == OP_TST1) || (op == OP_TST0);
  endfunction

  function automatic logic is_out_op(ioc_op_e op);
    return (op == OP_WR) || (op == OP_SET) || (op == OP_CLR);
  endfunction
endpackage

// File: rtl/ioc_decode.sv
module ioc_decode #(
  parameter int PW = 4,
  parameter int NP = 5
) (
  input  logic          valid,
  input  logic [PW-1:0] port,
  output logic [NP-1:0] sel,
  output logic          hit
);
  for (genvar i = 0; i < NP; i++) begin : g_sel
    assign sel[i] = valid && (port == PW'(i));
  end
  assign hit = |sel;
endmodule

// File: rtl/ioc_port.sv
module ioc_port
  import ioc_pkg::*;
#(
  parameter int        W    = 4,
  parameter ioc_kind_e KIND = K_OUT
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         bkp,
  input  logic         sel,
  input  ioc_op_e      op,
  input  logic [W-1:0] arg,
  input  logic [W-1:0] pad_i,
  output logic [W-1:0] pad_o,
  output logic [W-1:0] oe_o,
  output logic [W-1:0] rval_o
);
  logic [W-1:0] lat_q;

  always_ff @(posedge clk) begin
    if (rst) lat_q <= '0;
    else if (sel) begin
      case (op)
        OP_WR:   lat_q <= arg;
        OP_SET:  lat_q <= lat_q | arg;
        OP_CLR:  lat_q <= lat_q & ~arg;
        default: ;
      endcase
    end
  end
  assign pad_o = lat_q;

  a_r5_set_keeps: assert property (@(posedge clk) disable iff (rst)
    (sel && op == OP_SET) |=> (((pad_o & ~$past(arg)) == ($past(pad_o) & ~$past(arg)))
                               && ((pad_o & $past(arg)) == $past(arg))));
  a_r9_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !sel |=> $stable(pad_o));

  if (KIND == K_AUTO) begin : g_auto
    logic mode_q;
    always_ff @(posedge clk) begin
      if (rst) mode_q <= 1'b0;
      else if (sel && is_out_op(op)) mode_q <= 1'b1;
      else if (sel && is_in_op(op)) mode_q <= 1'b0;
    end
    assign oe_o   = bkp ? '0 : {W{mode_q}};
    assign rval_o = bkp ? '0 : pad_i;

    a_r2_auto_out: assert property (@(posedge clk) disable iff (rst)
      (sel && is_out_op(op)) |=> (bkp || oe_o == '1));
    a_r3_auto_in: assert property (@(posedge clk) disable iff (rst)
      (sel && is_in_op(op)) |=> (oe_o == '0));
  end else if (KIND == K_BIT) begin : g_bit
    logic [W-1:0] dir_q;
    always_ff @(posedge clk) begin
      if (rst) dir_q <= '0;
      else if (sel && op == OP_DIR) dir_q <= arg;
    end
    assign oe_o   = bkp ? '0 : dir_q;
    assign rval_o = bkp ? '0 : ((dir_q & lat_q) | (~dir_q & pad_i));

    a_r4_dir_load: assert property (@(posedge clk) disable iff (rst)
      (sel && op == OP_DIR) |=> (bkp || oe_o == $past(arg)));
  end else if (KIND == K_OD) begin : g_od
    logic unused_pad;
    assign unused_pad = ^pad_i;
    assign oe_o   = bkp ? '0 : lat_q;
    assign rval_o = lat_q;
  end else begin : g_out
    logic unused_pad;
    assign unused_pad = ^pad_i;
    assign oe_o   = bkp ? '0 : '1;
    assign rval_o = lat_q;
  end
endmodule

// File: rtl/io_port_ctrl.sv
module io_port_ctrl
  import ioc_pkg::*;
#(
  parameter int W  = 4,
  parameter int PW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          backup_i,
  input  logic          cmd_valid_i,
  input  logic [2:0]    cmd_op_i,
  input  logic [PW-1:0] cmd_port_i,
  input  logic [W-1:0]  cmd_arg_i,
  input  logic [W-1:0]  in_pad_i,
  input  logic [W-1:0]  auto_pad_i,
  input  logic [W-1:0]  dir_pad_i,
  output logic [W-1:0]  out_data_o,
  output logic [W-1:0]  out_oe_o,
  output logic [W-1:0]  auto_data_o,
  output logic [W-1:0]  auto_oe_o,
  output logic [W-1:0]  dir_data_o,
  output logic [W-1:0]  dir_oe_o,
  output logic [W-1:0]  od_pull_o,
  output logic [W-1:0]  rd_data_o,
  output logic          skip_o
);
  ioc_op_e           op;
  logic [N_PORTS-1:0] sel;
  logic               hit;
  logic               bkp_q;
  logic [W-1:0]       v_in, v_out, v_auto, v_bit, v_od, val;
  logic [W-1:0]       unused_od_pad;
  logic [W-1:0]       rd_q;
  logic               skip_q;

  assign op = ioc_op_e'(cmd_op_i);

  always_ff @(posedge clk) begin
    if (rst) bkp_q <= 1'b0;
    else     bkp_q <= backup_i;
  end

  ioc_decode #(.PW(PW), .NP(N_PORTS)) u_dec (
    .valid(cmd_valid_i), .port(cmd_port_i), .sel(sel), .hit(hit));

  ioc_port #(.W(W), .KIND(K_OUT)) u_out (
    .clk(clk), .rst(rst), .bkp(bkp_q), .sel(sel[PN_OUT]), .op(op), .arg(cmd_arg_i),
    .pad_i('0), .pad_o(out_data_o), .oe_o(out_oe_o), .rval_o(v_out));
  ioc_port #(.W(W), .KIND(K_AUTO)) u_auto (
    .clk(clk), .rst(rst), .bkp(bkp_q), .sel(sel[PN_AUTO]), .op(op), .arg(cmd_arg_i),
    .pad_i(auto_pad_i), .pad_o(auto_data_o), .oe_o(auto_oe_o), .rval_o(v_auto));
  ioc_port #(.W(W), .KIND(K_BIT)) u_bit (
    .clk(clk), .rst(rst), .bkp(bkp_q), .sel(sel[PN_BIT]), .op(op), .arg(cmd_arg_i),
    .pad_i(dir_pad_i), .pad_o(dir_data_o), .oe_o(dir_oe_o), .rval_o(v_bit));
  ioc_port #(.W(W), .KIND(K_OD)) u_od (
    .clk(clk), .rst(rst), .bkp(bkp_q), .sel(sel[PN_OD]), .op(op), .arg(cmd_arg_i),
    .pad_i('0), .pad_o(unused_od_pad), .oe_o(od_pull_o), .rval_o(v_od));

  assign v_in = bkp_q ? '0 : in_pad_i;

  always_comb begin
    val = '0;
    if (sel[PN_IN])   val = v_in;
    if (sel[PN_OUT])  val = v_out;
    if (sel[PN_AUTO]) val = v_auto;
    if (sel[PN_BIT])  val = v_bit;
    if (sel[PN_OD])   val = v_od;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q   <= '0;
      skip_q <= 1'b0;
    end else begin
      skip_q <= 1'b0;
      if (cmd_valid_i) begin
        case (op)
          OP_RD:   rd_q   <= val;
          OP_TST1: skip_q <= ((val & cmd_arg_i) == cmd_arg_i);
          OP_TST0: skip_q <= ((val & cmd_arg_i) == '0);
          default: ;
        endcase
      end
    end
  end
  assign rd_data_o = rd_q;
  assign skip_o    = skip_q;

  a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (out_oe_o == '1 && out_data_o == '0 && auto_oe_o == '0
                    && dir_oe_o == '0 && od_pull_o == '0));
  a_r7_backup_idle: assert property (@(posedge clk) disable iff (rst)
    backup_i |=> (out_oe_o == '0 && auto_oe_o == '0 && dir_oe_o == '0 && od_pull_o == '0));
  a_r9_unimpl_zero: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid_i && !hit && op == OP_RD) |=> (rd_data_o == '0));
  a_r6_skip_source: assert property (@(posedge clk) disable iff (rst)
    skip_o |-> ($past(cmd_valid_i) && ($past(cmd_op_i) == 3'd5 || $past(cmd_op_i) == 3'd6)));
endmodule

// File: tb/tb_io_port_ctrl.sv
module tb_io_port_ctrl;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       backup_i = 1'b0;
  logic       cmd_valid_i = 1'b0;
  logic [2:0] cmd_op_i = 3'd0;
  logic [3:0] cmd_port_i = 4'd0;
  logic [3:0] cmd_arg_i = 4'd0;
  logic [3:0] in_pad_i = 4'd0;
  logic [3:0] auto_pad_i = 4'd0;
  logic [3:0] dir_pad_i = 4'd0;
  logic [3:0] out_data_o, out_oe_o, auto_data_o, auto_oe_o;
  logic [3:0] dir_data_o, dir_oe_o, od_pull_o, rd_data_o;
  logic       skip_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  io_port_ctrl dut (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cmd(int op, int port, logic [3:0] arg);
    @(negedge clk);
    cmd_valid_i = 1'b1; cmd_op_i = op[2:0]; cmd_port_i = port[3:0]; cmd_arg_i = arg;
    @(negedge clk);
    cmd_valid_i = 1'b0; cmd_op_i = 3'd0;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 out_oe", out_oe_o, 4'hF);
    check("R1 out_data", out_data_o, 4'h0);
    check("R1 auto_oe", auto_oe_o, 4'h0);
    check("R1 dir_oe", dir_oe_o, 4'h0);
    check("R1 od_pull", od_pull_o, 4'h0);
    check("R1 rd/skip", {rd_data_o, 3'b0, skip_o}, 8'h00);
  endtask

  task automatic t_setclr();
    cmd(2, 1, 4'hA); check("R5 write", out_data_o, 4'hA);
    cmd(3, 1, 4'h4); check("R5 set", out_data_o, 4'hE);
    cmd(4, 1, 4'h9); check("R5 clear", out_data_o, 4'h6);
    cmd(1, 1, 4'h0); check("R10 read latch", rd_data_o, 4'h6);
  endtask

  task automatic t_auto();
    auto_pad_i = 4'h5;
    cmd(2, 2, 4'h3); check("R2 write oe", auto_oe_o, 4'hF); check("R2 data", auto_data_o, 4'h3);
    cmd(1, 2, 4'h0); check("R3 read oe", auto_oe_o, 4'h0); check("R3 read pad", rd_data_o, 4'h5);
    cmd(3, 2, 4'h8); check("R2 set oe", auto_oe_o, 4'hF); check("R5 set auto", auto_data_o, 4'hB);
    cmd(5, 2, 4'h4); check("R3 tst1 oe", auto_oe_o, 4'h0); check("R3 tst1 skip", skip_o, 1'b1);
    cmd(4, 2, 4'h1); check("R2 clr oe", auto_oe_o, 4'hF); check("R5 clr auto", auto_data_o, 4'hA);
    cmd(6, 2, 4'hA); check("R3 tst0 oe", auto_oe_o, 4'h0); check("R3 tst0 skip", skip_o, 1'b1);
  endtask

  task automatic t_collide_read();
    cmd(2, 2, 4'h2);
    auto_pad_i = 4'hC;
    cmd(1, 2, 4'h0);
    check("R3 same-edge oe", auto_oe_o, 4'h0);
    check("R3 same-edge pad", rd_data_o, 4'hC);
  endtask

  task automatic t_bitdir();
    dir_pad_i = 4'hC;
    cmd(2, 3, 4'h5); check("R4 no dir change", dir_oe_o, 4'h0); check("R4 latch", dir_data_o, 4'h5);
    cmd(7, 3, 4'h3); check("R4 dir load", dir_oe_o, 4'h3);
    cmd(1, 3, 4'h0); check("R4 mixed read", rd_data_o, 4'hD);
  endtask

  task automatic t_tests();
    in_pad_i = 4'h6;
    cmd(5, 0, 4'h6); check("R6 tst1 all ones", skip_o, 1'b1);
    @(negedge clk);  check("R6 skip one cycle", skip_o, 1'b0);
    cmd(5, 0, 4'h7); check("R6 tst1 partial", skip_o, 1'b0);
    cmd(6, 0, 4'h9); check("R6 tst0 all zero", skip_o, 1'b1);
    cmd(6, 0, 4'h2); check("R6 tst0 one set", skip_o, 1'b0);
    cmd(5, 0, 4'h0); check("R6 zero mask", skip_o, 1'b1);
  endtask

  task automatic t_od();
    cmd(2, 4, 4'h5); check("R8 pull", od_pull_o, 4'h5);
    cmd(4, 4, 4'h4); check("R8 release", od_pull_o, 4'h1);
  endtask

  task automatic t_backup();
    @(negedge clk); backup_i = 1'b1;
    @(negedge clk);
    check("R7 out_oe", out_oe_o, 4'h0);
    check("R7 dir_oe", dir_oe_o, 4'h0);
    check("R7 od", od_pull_o, 4'h0);
    cmd(1, 0, 4'h0); check("R7 input read", rd_data_o, 4'h0);
    cmd(1, 1, 4'h0);
    cmd(1, 3, 4'h0); check("R7 bit read", rd_data_o, 4'h0);
    cmd(2, 1, 4'h3); check("R7 write held off", out_oe_o, 4'h0);
    @(negedge clk); backup_i = 1'b0;
    @(negedge clk);
    check("R7 restore oe", out_oe_o, 4'hF);
    check("R7 written data", out_data_o, 4'h3);
    check("R7 restore dir", dir_oe_o, 4'h3);
    check("R7 restore od", od_pull_o, 4'h1);
  endtask

  task automatic t_unimpl();
    cmd(1, 0, 4'h0); check("R10 read port0", rd_data_o, 4'h6);
    cmd(1, 9, 4'h0); check("R9 read zero", rd_data_o, 4'h0);
    cmd(2, 7, 4'hF);
    check("R9 no out change", out_data_o, 4'h3);
    check("R9 no od change", od_pull_o, 4'h1);
    cmd(6, 12, 4'hF); check("R9 tst0 skip", skip_o, 1'b1);
    cmd(5, 15, 4'h1); check("R9 tst1 no skip", skip_o, 1'b0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_setclr();
    t_auto();
    t_collide_read();
    t_bitdir();
    t_tests();
    t_od();
    t_backup();
    t_unimpl();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule